// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity Error Signalling

This block is an asynchronous serial transceiver for a smart-card style link where transmit and receive share a single open-drain wire. The block never drives the wire high. It only asserts a pull-low request, and the wire level is the wired-AND of every party on it. Because the wire is shared, the receiver always hears the block's own outgoing frames when reception is enabled.

A frame has eleven bit slots. The first is a low start bit. Eight data bits follow, least-significant first. Then comes a parity bit and a high stop bit. Each slot lasts 16 × (n + 1) clock cycles, where n is the divider input.

Software loads one byte into a transmit buffer. The buffer feeds a shift register. When the receiver finds a parity mismatch, it holds the wire low for the whole stop slot so that the sender can see the rejection. While the transmitter sends its own stop bit, it samples the wire, so it learns about such a rejection from the far end.

Status flags and two interrupt requests are brought out as plain signals. Single-cycle strobes clear them.

Top module: `sc_uart`

## Requirements
- R1: After reset: `tbuf_empty`=1, `tshift_empty`=1, `rx_ready`=0, `tx_irq`=0, `rx_irq`=0, `parity_fault`=0, `echo_fault`=0, and `line_pull_low`=0.
- R2: Every bit slot on the wire lasts exactly 16 × (`div_n` + 1) clock cycles.
- R3: A transmitted frame has eleven slots in this order:
  - a low start slot;
  - data bits 0 to 7, LSB first;
  - a parity bit equal to the XOR of the data bits, inverted when `parity_odd`=1;
  - a high stop slot.
- R4: A frame starts only while `tx_enable`=1 and the buffer holds a byte.
  - `tbuf_empty` rises when the byte moves into the shift register.
  - `tshift_empty` is 0 while a frame is on the wire and returns to 1 when it ends.
- R5: Transmit interrupt source:
  - With `txirq_on_done`=0, `tx_irq` sets when the buffer hands its byte to the shifter.
  - With `txirq_on_done`=1, it sets only when the frame completes.
  - `tx_irq_ack` clears it.
- R6: With `rx_enable`=1, a frame on the wire is received.
  - At the end of its stop slot, `rx_ready` and `rx_irq` set and `rd_byte` holds the byte.
  - `rd_en` clears `rx_ready`, and `rx_irq_ack` clears `rx_irq`.
- R7: When the received parity bit does not match, the block pulls the wire low through the stop slot and sets `parity_fault`. When parity matches, the wire is left released.
- R8: With `rx_enable`=0, incoming frames have no effect: no `rx_ready`, no `rx_irq`, no `parity_fault` and no error pulse.
- R9: A low level that has ended before mid-bit of a would-be start slot is discarded. No byte is delivered, and the next real frame is received correctly.
- R10: `echo_fault` sets when the wire reads low at mid-slot of the block's own stop bit. `fault_clr` clears both `echo_fault` and `parity_fault`.
- R11: With `rx_enable`=1, the block receives its own transmitted byte.
- R12: A byte written while a frame is shifting is sent as the next frame, which starts right after the current stop slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | DIV_W | Baud divider value n |
| tx_enable | input | 1 | Allows frames to start |
| rx_enable | input | 1 | Allows reception |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| txirq_on_done | input | 1 | Transmit interrupt source select |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_byte | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears `rx_ready` |
| rd_byte | output | DATA_W | Last received byte |
| line_in | input | 1 | Sensed level of the shared wire |
| line_pull_low | output | 1 | Open-drain request to pull the wire low |
| tbuf_empty | output | 1 | Transmit buffer empty |
| tshift_empty | output | 1 | Transmit shifter idle |
| rx_ready | output | 1 | Received byte waiting |
| parity_fault | output | 1 | Sticky received-parity error |
| echo_fault | output | 1 | Sticky: wire low during own stop slot |
| fault_clr | input | 1 | Clears both sticky faults |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_irq_ack | input | 1 | Clears `tx_irq` |
| rx_irq | output | 1 | Receive interrupt request |
| rx_irq_ack | input | 1 | Clears `rx_irq` |

## Verification
The bench models the wire as a wired-AND of the block and a card. It decodes frames at mid-slot and measures the start slot in cycles. A design with an off-by-one divider would therefore show a wrong slot length, and a wrong bit order or parity sense would decode to a different byte or parity bit.

The bench aims at these corner cases:
- A short low glitch. A receiver without a mid-bit start check would deliver a phantom byte or go out of step with the next frame.
- A bad parity bit with reception disabled. A receiver that ignores the enable would raise a spurious error pulse.
- A byte written mid-frame. A shifter that does not reload at the final tick would leave a gap or lose the byte.
- The two transmit interrupt sources. These are checked in the middle of a frame, where selecting the wrong source makes the request appear one frame time too early or too late.

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic              parity_odd,
  input  logic              txirq_on_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_byte,
  input  logic              line_in,
  output logic              line_pull_low,
  output logic              tbuf_empty,
  output logic              tshift_empty,
  output logic              rx_ready,
  output logic              parity_fault,
  output logic              echo_fault,
  input  logic              fault_clr,
  output logic              tx_irq,
  input  logic              tx_irq_ack,
  output logic              rx_irq,
  input  logic              rx_irq_ack
);
  localparam int LAST  = DATA_W + 2;
  localparam int BIT_W = $clog2(LAST + 2);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [BIT_W-1:0] B_LAST = BIT_W'(LAST);
  localparam logic [BIT_W-1:0] B_PAR  = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] B_DMAX = BIT_W'(DATA_W);
  localparam logic [SUB_W-1:0] S_END  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] S_MID  = SUB_W'(OVS / 2 - 1);

  logic [1:0] sync_q;
  logic       line_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};

  assign line_s = sync_q[1];

  logic [DATA_W-1:0] tbuf, tx_sh;
  logic              tbuf_full, tx_busy, tx_par, tx_val;
  logic [DIV_W-1:0]  tx_pre;
  logic [SUB_W-1:0]  tx_sub;
  logic [BIT_W-1:0]  tx_bit;
  logic              tx_tick, tx_done, tx_load, tx_data_bit;

  assign tx_tick     = tx_pre == div_n;
  assign tx_done     = tx_busy && tx_tick && tx_sub == S_END && tx_bit == B_LAST;
  assign tx_load     = tbuf_full && tx_enable && (!tx_busy || tx_done);
  assign tx_data_bit = tx_bit != '0 && tx_bit <= B_DMAX;

  always_comb begin
    if (tx_bit == '0)         tx_val = 1'b0;
    else if (tx_bit == B_PAR)  tx_val = tx_par;
    else if (tx_bit == B_LAST) tx_val = 1'b1;
    else                       tx_val = tx_sh[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf       <= '0;
      tx_sh      <= '0;
      tbuf_full  <= 1'b0;
      tx_busy    <= 1'b0;
      tx_par     <= 1'b0;
      tx_pre     <= '0;
      tx_sub     <= '0;
      tx_bit     <= '0;
      tx_irq     <= 1'b0;
      echo_fault <= 1'b0;
    end else begin
      if (fault_clr)  echo_fault <= 1'b0;
      if (tx_irq_ack) tx_irq <= 1'b0;
      if (tx_busy) begin
        if (tx_tick) begin
          tx_pre <= '0;
          if (tx_sub == S_END) begin
            tx_sub <= '0;
            tx_bit <= tx_bit + 1'b1;
            if (tx_data_bit) tx_sh <= tx_sh >> 1;
          end else begin
            tx_sub <= tx_sub + 1'b1;
          end
          if (tx_sub == S_MID && tx_bit == B_LAST && !line_s) echo_fault <= 1'b1;
        end else begin
          tx_pre <= tx_pre + 1'b1;
        end
      end
      if (tx_done) begin
        tx_busy <= 1'b0;
        tx_bit  <= '0;
        if (txirq_on_done) tx_irq <= 1'b1;
      end
      if (tx_load) begin
        tx_busy   <= 1'b1;
        tx_sh     <= tbuf;
        tx_par    <= (^tbuf) ^ parity_odd;
        tx_pre    <= '0;
        tx_sub    <= '0;
        tx_bit    <= '0;
        tbuf_full <= 1'b0;
        if (!txirq_on_done) tx_irq <= 1'b1;
      end
      if (wr_en) begin
        tbuf      <= wr_byte;
        tbuf_full <= 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] rx_sh;
  logic              rx_busy, rx_perr, rx_drv, rx_tick, rx_done;
  logic [DIV_W-1:0]  rx_pre;
  logic [SUB_W-1:0]  rx_sub;
  logic [BIT_W-1:0]  rx_bit;

  assign rx_tick = rx_pre == div_n;
  assign rx_done = rx_enable && rx_busy && rx_tick && rx_sub == S_END && rx_bit == B_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh        <= '0;
      rd_byte      <= '0;
      rx_busy      <= 1'b0;
      rx_perr      <= 1'b0;
      rx_drv       <= 1'b0;
      rx_pre       <= '0;
      rx_sub       <= '0;
      rx_bit       <= '0;
      rx_ready     <= 1'b0;
      rx_irq       <= 1'b0;
      parity_fault <= 1'b0;
    end else begin
      if (fault_clr)  parity_fault <= 1'b0;
      if (rx_irq_ack) rx_irq <= 1'b0;
      if (rd_en)      rx_ready <= 1'b0;
      if (!rx_enable) begin
        rx_busy <= 1'b0;
        rx_drv  <= 1'b0;
      end else if (!rx_busy) begin
        if (!line_s) begin
          rx_busy <= 1'b1;
          rx_pre  <= '0;
          rx_sub  <= '0;
          rx_bit  <= '0;
          rx_perr <= 1'b0;
        end
      end else if (rx_tick) begin
        rx_pre <= '0;
        if (rx_sub == S_MID) begin
          if (rx_bit == '0) begin
            if (line_s) rx_busy <= 1'b0;
          end else if (rx_bit <= B_DMAX) begin
            rx_sh <= {line_s, rx_sh[DATA_W-1:1]};
          end else if (rx_bit == B_PAR) begin
            rx_perr <= line_s ^ (^rx_sh) ^ parity_odd;
          end
        end
        if (rx_sub == S_END) begin
          rx_sub <= '0;
          if (rx_bit == B_PAR && rx_perr) begin
            rx_drv       <= 1'b1;
            parity_fault <= 1'b1;
          end
          if (rx_bit == B_LAST) begin
            rx_busy  <= 1'b0;
            rx_drv   <= 1'b0;
            rd_byte  <= rx_sh;
            rx_ready <= 1'b1;
            rx_irq   <= 1'b1;
          end else begin
            rx_bit <= rx_bit + 1'b1;
          end
        end else begin
          rx_sub <= rx_sub + 1'b1;
        end
      end else begin
        rx_pre <= rx_pre + 1'b1;
      end
    end
  end

  assign line_pull_low = (tx_busy && !tx_val) || rx_drv;
  assign tbuf_empty    = !tbuf_full;
  assign tshift_empty  = !tx_busy;

  // R4
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_enable && tbuf_full));

  // R4
  tbuf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbuf_full) |-> $past(wr_en));

  // R5
  txirq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_irq) && $past(txirq_on_done)) |-> $past(tx_busy && tx_bit == B_LAST));

  // R6
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_busy && rx_bit == B_LAST && rx_enable));

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_done) |=> !rx_ready);

  // R7
  err_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drv |-> (rx_busy && rx_bit == B_LAST));
endmodule

// File: tb/sc_uart_bench.sv
module sc_uart_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_n = 8'd1;
  logic       tx_enable = 1'b1, rx_enable = 1'b1, parity_odd = 1'b0, txirq_on_done = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, fault_clr = 1'b0, tx_irq_ack = 1'b0, rx_irq_ack = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       line_pull_low, tbuf_empty, tshift_empty, rx_ready;
  logic       parity_fault, echo_fault, tx_irq, rx_irq;
  logic       card_low = 1'b0;
  wire        line = !(line_pull_low || card_low);

  int checks = 0, errors = 0, bt = 32;

  always #(CLK_P / 2) clk = !clk;

  sc_uart u_sc_uart (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .parity_odd(parity_odd), .txirq_on_done(txirq_on_done), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_byte(rd_byte), .line_in(line), .line_pull_low(line_pull_low),
    .tbuf_empty(tbuf_empty), .tshift_empty(tshift_empty), .rx_ready(rx_ready),
    .parity_fault(parity_fault), .echo_fault(echo_fault), .fault_clr(fault_clr),
    .tx_irq(tx_irq), .tx_irq_ack(tx_irq_ack), .rx_irq(rx_irq), .rx_irq_ack(rx_irq_ack)
  );

  function automatic logic exp_par(logic [7:0] b, logic odd);
    return (^b) ^ odd;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_div(int n);
    div_n = 8'(n);
    bt = 16 * (n + 1);
  endtask

  task automatic write_byte(logic [7:0] b);
    wr_byte = b; wr_en = 1'b1; tick(1); wr_en = 1'b0;
  endtask

  task automatic clear_all();
    rd_en = 1'b1; tx_irq_ack = 1'b1; rx_irq_ack = 1'b1; fault_clr = 1'b1;
    tick(1);
    rd_en = 1'b0; tx_irq_ack = 1'b0; rx_irq_ack = 1'b0; fault_clr = 1'b0;
  endtask

  task automatic wait_start(string req);
    int n = 0;
    while (line && n < 20 * bt) begin tick(1); n++; end
    check(req, {31'd0, line}, 32'd0);
  endtask

  task automatic capture(string req, output logic [7:0] d, output logic p, output logic s);
    wait_start(req);
    tick(bt / 2);
    for (int i = 0; i < 8; i++) begin tick(bt); d[i] = line; end
    tick(bt); p = line;
    tick(bt); s = line;
  endtask

  task automatic card_send(logic [7:0] b, logic bad, output logic stop_low);
    logic [10:0] v;
    v = {1'b1, exp_par(b, parity_odd) ^ bad, b, 1'b0};
    for (int i = 0; i < 10; i++) begin card_low = !v[i]; tick(bt); end
    card_low = 1'b0;
    tick(bt / 2); stop_low = !line;
    tick(bt - bt / 2);
  endtask

  task automatic tx_frame_check(string req, logic [7:0] b);
    logic [7:0] d; logic p, s;
    capture(req, d, p, s);
    check(req, {24'd0, d}, {24'd0, b});
    check(req, {31'd0, p}, {31'd0, exp_par(b, parity_odd)});
    check(req, {31'd0, s}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    logic sl;
    int len;
    void'($urandom(32'd20240611));
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 tbuf_empty", {31'd0, tbuf_empty}, 1);
    check("R1 tshift_empty", {31'd0, tshift_empty}, 1);
    check("R1 rx_ready", {31'd0, rx_ready}, 0);
    check("R1 irqs", {30'd0, tx_irq, rx_irq}, 0);
    check("R1 faults", {30'd0, parity_fault, echo_fault}, 0);
    check("R1 line", {31'd0, line_pull_low}, 0);

    // R2 start slot length for several dividers
    for (int n = 0; n < 4; n++) begin
      set_div(n);
      write_byte(8'h35);
      wait_start("R2 start");
      len = 0;
      while (!line && len < 200) begin tick(1); len++; end
      check("R2 bit time", len, bt);
      tick(12 * bt);
      clear_all();
    end

    // R3 R11 random frames, loopback
    for (int k = 0; k < 8; k++) begin
      set_div($urandom_range(0, 3));
      parity_odd = 1'($urandom_range(0, 1));
      b = 8'($urandom);
      write_byte(b);
      tx_frame_check("R3 frame", b);
      tick(bt);
      check("R4 shift idle", {31'd0, tshift_empty}, 1);
      check("R11 loopback ready", {31'd0, rx_ready}, 1);
      check("R11 loopback byte", {24'd0, rd_byte}, {24'd0, b});
      check("R10 no echo fault", {31'd0, echo_fault}, 0);
      check("R7 no parity fault", {31'd0, parity_fault}, 0);
      clear_all();
      check("R6 read clears", {31'd0, rx_ready}, 0);
    end
    parity_odd = 1'b0;
    set_div(1);

    // R4 transmit held while disabled
    tx_enable = 1'b0;
    write_byte(8'hC3);
    len = 0;
    for (int i = 0; i < 3 * bt; i++) begin tick(1); if (!line) len++; end
    check("R4 no frame when disabled", len, 0);
    check("R4 buffer held", {31'd0, tbuf_empty}, 0);
    check("R4 shifter idle", {31'd0, tshift_empty}, 1);
    tx_enable = 1'b1;
    tick(3);
    check("R4 buffer emptied", {31'd0, tbuf_empty}, 1);
    check("R4 shifter busy", {31'd0, tshift_empty}, 0);
    tx_frame_check("R4 frame after enable", 8'hC3);
    tick(bt);
    clear_all();

    // R5 interrupt on buffer transfer
    txirq_on_done = 1'b0;
    write_byte(8'h5A);
    tick(2);
    check("R5 irq on transfer", {31'd0, tx_irq}, 1);
    check("R5 frame still shifting", {31'd0, tshift_empty}, 0);
    tx_irq_ack = 1'b1; tick(1); tx_irq_ack = 1'b0;
    check("R5 ack clears", {31'd0, tx_irq}, 0);
    tick(12 * bt);
    check("R5 no second irq", {31'd0, tx_irq}, 0);
    clear_all();
    // R5 interrupt on frame completion
    txirq_on_done = 1'b1;
    write_byte(8'hA6);
    tick(bt);
    check("R5 no irq mid frame", {31'd0, tx_irq}, 0);
    tick(11 * bt);
    check("R5 irq at completion", {31'd0, tx_irq}, 1);
    check("R5 shifter idle", {31'd0, tshift_empty}, 1);
    clear_all();
    txirq_on_done = 1'b0;

    // R12 back-to-back
    b = 8'($urandom); b2 = 8'($urandom);
    write_byte(b);
    tick(4);
    write_byte(b2);
    tx_frame_check("R12 first", b);
    tick(bt / 2 - 1);
    check("R12 second started", {31'd0, line}, 0);
    check("R12 buffer handed over", {31'd0, tbuf_empty}, 1);
    tx_frame_check("R12 second", b2);
    tick(bt);
    check("R12 last byte received", {24'd0, rd_byte}, {24'd0, b2});
    clear_all();

    // R6 R7 card frames with good and bad parity
    for (int k = 0; k < 6; k++) begin
      set_div($urandom_range(0, 3));
      parity_odd = 1'($urandom_range(0, 1));
      b = 8'($urandom);
      card_send(b, k[0], sl);
      tick(bt);
      check("R7 error pulse", {31'd0, sl}, {31'd0, k[0]});
      check("R7 parity fault", {31'd0, parity_fault}, {31'd0, k[0]});
      check("R6 rx ready", {31'd0, rx_ready}, 1);
      check("R6 rx irq", {31'd0, rx_irq}, 1);
      check("R6 rx byte", {24'd0, rd_byte}, {24'd0, b});
      clear_all();
      check("R10 fault clear", {31'd0, parity_fault}, 0);
      check("R6 irq ack", {31'd0, rx_irq}, 0);
    end
    parity_odd = 1'b0;
    set_div(1);

    // R8 disabled receiver ignores bad frame
    rx_enable = 1'b0;
    card_send(8'h81, 1'b1, sl);
    tick(bt);
    check("R8 no error pulse", {31'd0, sl}, 0);
    check("R8 no rx ready", {31'd0, rx_ready}, 0);
    check("R8 no rx irq", {31'd0, rx_irq}, 0);
    check("R8 no parity fault", {31'd0, parity_fault}, 0);
    rx_enable = 1'b1;
    tick(2);

    // R9 short glitch
    card_low = 1'b1; tick(bt / 4); card_low = 1'b0;
    tick(2 * bt);
    check("R9 glitch ignored", {31'd0, rx_ready}, 0);
    check("R9 line released", {31'd0, line}, 1);
    card_send(8'h6E, 1'b0, sl);
    tick(bt);
    check("R9 next frame ok", {24'd0, rd_byte}, 32'h6E);
    clear_all();

    // R10 echo fault on own stop slot
    rx_enable = 1'b0;
    write_byte(8'h17);
    wait_start("R10 start");
    tick(10 * bt + 2);
    card_low = 1'b1; tick(bt - 4); card_low = 1'b0;
    tick(bt);
    check("R10 echo fault", {31'd0, echo_fault}, 1);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    check("R10 echo clear", {31'd0, echo_fault}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule